// File: doc/BRIEF.md
# Floating-Point Control and Status Register

This block is the control and status register that sits beside a packed single-precision floating-point datapath. It keeps six sticky exception flags, six matching exception masks, a two-bit rounding-mode field, a flush-to-zero control and a denormals-are-zero control. It also decodes these controls into ready-to-use signals for the arithmetic units. Software loads the register through a write-enable and data port and reads it back on a read-data port. Execution units report exception events on a 6-bit input every cycle. Each event ORs into its flag. An event whose mask is clear also raises a trap request in the same cycle.

A read-only capability mask reports which register bits are writable. A parameter controls whether denormals-are-zero exists. When it does not, bit 6 is reserved like bits 16 to 31. A write that sets any bit outside the capability mask is discarded and produces a one-cycle fault pulse. Events that arrive in the same cycle still accumulate.

Top module: `fpctl_csr`

## Requirements
- R1: After reset the register reads 0x00001F80: all six masks set, round-to-nearest selected, all flags, flush-to-zero and denormals-are-zero clear, and no fault.
- R2: Register layout as read on `sw_rd_data`:
  - Flags sit in bits 0..5, in the order invalid, denormal, divide-by-zero, overflow, underflow, precision.
  - Bit 6 is denormals-are-zero.
  - Masks sit in bits 7..12, in the same exception order.
  - Rounding control is bits 14:13 and flush-to-zero is bit 15.
  - Bits 31..16 always read 0.
- R3: A flag that is 1 stays 1 until an accepted software write puts 0 in it. Events never clear a flag.
- R4: A 1 on `exc_evt[i]` sets flag i from the next cycle on, whatever the state of mask i.
- R5: `trap_req[i]` is high in the same cycle as `exc_evt[i]` exactly when mask bit i+7, as currently held, is 0.
- R6: An accepted write takes effect on the next clock edge. When events arrive in the same cycle, they are ORed into the written flag bits.
- R7: A write with any 1 outside `cap_mask` leaves bits 6..31 unchanged. It also leaves the flags unchanged, apart from events ORed in during that cycle. `wr_fault` is high for exactly the one cycle after such a write and is low otherwise.
- R8: `cap_mask` reads 0x0000FFFF when denormals-are-zero is supported (HAS_DAZ=1) and 0x0000FFBF when it is not. In the unsupported case bit 6 counts as reserved.
- R9: Exactly one rounding output is high:
  - `rnd_nearest` for field value 00
  - `rnd_down` for 01 (bit 13 only)
  - `rnd_up` for 10 (bit 14 only)
  - `rnd_zero` for 11
- R10: `ftz_en` equals register bit 15 and `daz_en` equals register bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sw_wr_en | input | 1 | Software write strobe |
| sw_wr_data | input | 32 | Software write value |
| sw_rd_data | output | 32 | Current register value |
| cap_mask | output | 32 | Writable-bit capability mask |
| wr_fault | output | 1 | One-cycle pulse after a write that touched a reserved bit |
| exc_evt | input | 6 | Exception events from execution units, flag order |
| trap_req | output | 6 | Per-exception trap request for unmasked events |
| rnd_nearest | output | 1 | Round-to-nearest selected |
| rnd_down | output | 1 | Round toward negative selected |
| rnd_up | output | 1 | Round toward positive selected |
| rnd_zero | output | 1 | Round toward zero selected |
| ftz_en | output | 1 | Flush-to-zero enable |
| daz_en | output | 1 | Denormals-are-zero enable |

## Verification
The hardest situation to reach from the ports is a rejected write that coincides with live events. In that cycle the flags must still pick up the events while the rest of the register holds. The same stimulus must also fault on a part without denormals-are-zero and pass on one that has it. The bench drives two instances, one with the feature and one without, from the same stream. Random writes regularly carry bit 6 or a high reserved bit and overlap with dense event bursts. Directed cycles pin down each of these combinations and each rounding code.

// File: rtl/fcsr_pkg.sv
package fcsr_pkg;
  localparam int N_EXC   = 6;
  localparam int DEF_W   = 16;
  localparam int DAZ_POS = 6;
  localparam logic [DEF_W-1:0] FCSR_RST = 16'h1F80;

  typedef enum logic [1:0] {
    RC_NEAREST = 2'b00,
    RC_DOWN    = 2'b01,
    RC_UP      = 2'b10,
    RC_ZERO    = 2'b11
  } rc_e;

  // Packed from bit 15 down to bit 0.
  typedef struct packed {
    logic             ftz;
    rc_e              rc;
    logic [N_EXC-1:0] msk;
    logic             daz;
    logic [N_EXC-1:0] flg;
  } fcsr_t;
endpackage

// File: rtl/fcsr_wr_check.sv
module fcsr_wr_check #(
  parameter int DW      = 32,
  parameter int DEFW    = 16,
  parameter bit HAS_DAZ = 1'b1
) (
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] cap_mask,
  output logic          wr_ok,
  output logic          wr_bad
);
  localparam logic [DW-1:0] DEF_MASK = {{(DW-DEFW){1'b0}}, {DEFW{1'b1}}};
  localparam logic [DW-1:0] DAZ_ONE  = {{(DW-1){1'b0}}, 1'b1} << fcsr_pkg::DAZ_POS;
  localparam logic [DW-1:0] CAP      = HAS_DAZ ? DEF_MASK : (DEF_MASK & ~DAZ_ONE);

  logic [DW-1:0] bad_bits;
  logic          any_bad;

  always_comb begin
    bad_bits = wr_data & ~CAP;
    any_bad  = |bad_bits;
    wr_bad   = wr_en & any_bad;
    wr_ok    = wr_en & ~any_bad;
  end

  assign cap_mask = CAP;
endmodule

// File: rtl/fcsr_flag_accum.sv
module fcsr_flag_accum #(
  parameter int N = 6
) (
  input  logic         wr_ok,
  input  logic [N-1:0] wr_flg,
  input  logic [N-1:0] cur_flg,
  input  logic [N-1:0] cur_msk,
  input  logic [N-1:0] evt,
  output logic [N-1:0] nxt_flg,
  output logic [N-1:0] trap
);
  for (genvar i = 0; i < N; i++) begin : g_exc
    logic base;
    always_comb begin
      base       = wr_ok ? wr_flg[i] : cur_flg[i];
      nxt_flg[i] = base | evt[i];
      trap[i]    = evt[i] & ~cur_msk[i];
    end
  end
endmodule

// File: rtl/fcsr_round_decode.sv
module fcsr_round_decode (
  input  fcsr_pkg::rc_e rc,
  output logic          is_nearest,
  output logic          is_down,
  output logic          is_up,
  output logic          is_zero
);
  always_comb begin
    is_nearest = 1'b0;
    is_down    = 1'b0;
    is_up      = 1'b0;
    is_zero    = 1'b0;
    unique case (rc)
      fcsr_pkg::RC_NEAREST: is_nearest = 1'b1;
      fcsr_pkg::RC_DOWN:    is_down    = 1'b1;
      fcsr_pkg::RC_UP:      is_up      = 1'b1;
      default:              is_zero    = 1'b1;
    endcase
  end
endmodule

// File: rtl/fpctl_csr.sv
module fpctl_csr #(
  parameter int DATA_W  = 32,
  parameter bit HAS_DAZ = 1'b1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sw_wr_en,
  input  logic [DATA_W-1:0]          sw_wr_data,
  output logic [DATA_W-1:0]          sw_rd_data,
  output logic [DATA_W-1:0]          cap_mask,
  output logic                       wr_fault,
  input  logic [fcsr_pkg::N_EXC-1:0] exc_evt,
  output logic [fcsr_pkg::N_EXC-1:0] trap_req,
  output logic                       rnd_nearest,
  output logic                       rnd_down,
  output logic                       rnd_up,
  output logic                       rnd_zero,
  output logic                       ftz_en,
  output logic                       daz_en
);
  import fcsr_pkg::*;

  localparam int PAD_W = DATA_W - DEF_W;

  // Reset synchronizer: assertion is asynchronous, release is synchronous.
  logic [1:0] rst_sync_q;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q_n = rst_sync_q[1];

  // Write legality check.
  logic wr_ok, wr_bad;

  fcsr_wr_check #(
    .DW     (DATA_W),
    .DEFW   (DEF_W),
    .HAS_DAZ(HAS_DAZ)
  ) u_wr_check (
    .wr_en   (sw_wr_en),
    .wr_data (sw_wr_data),
    .cap_mask(cap_mask),
    .wr_ok   (wr_ok),
    .wr_bad  (wr_bad)
  );

  // State and next state.
  fcsr_t csr_q, csr_d, wr_val;
  logic  fault_q;
  logic  csr_en;
  logic [N_EXC-1:0] nxt_flg;

  assign wr_val = fcsr_t'(sw_wr_data[DEF_W-1:0]);

  fcsr_flag_accum #(.N(N_EXC)) u_flags (
    .wr_ok  (wr_ok),
    .wr_flg (wr_val.flg),
    .cur_flg(csr_q.flg),
    .cur_msk(csr_q.msk),
    .evt    (exc_evt),
    .nxt_flg(nxt_flg),
    .trap   (trap_req)
  );

  always_comb begin
    csr_d     = wr_ok ? wr_val : csr_q;
    csr_d.flg = nxt_flg;
    csr_en    = wr_ok | (|exc_evt);
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      csr_q <= fcsr_t'(FCSR_RST);
    end else if (csr_en) begin
      csr_q <= csr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) fault_q <= 1'b0;
    else          fault_q <= wr_bad;
  end

  // Outputs.
  fcsr_round_decode u_round (
    .rc        (csr_q.rc),
    .is_nearest(rnd_nearest),
    .is_down   (rnd_down),
    .is_up     (rnd_up),
    .is_zero   (rnd_zero)
  );

  assign sw_rd_data = {{PAD_W{1'b0}}, csr_q};
  assign wr_fault   = fault_q;
  assign ftz_en     = csr_q.ftz;
  assign daz_en     = csr_q.daz;
endmodule

// File: rtl/fcsr_chk.sv
module fcsr_chk (
  input logic        clk,
  input logic        rst_q_n,
  input logic        sw_wr_en,
  input logic [31:0] sw_wr_data,
  input logic [31:0] sw_rd_data,
  input logic [31:0] cap_mask,
  input logic        wr_fault,
  input logic [5:0]  exc_evt,
  input logic [5:0]  trap_req,
  input logic        rnd_nearest,
  input logic        rnd_down,
  input logic        rnd_up,
  input logic        rnd_zero,
  input logic        ftz_en,
  input logic        daz_en
);
  p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
    sw_rd_data[31:16] == 16'h0);

  p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_q_n)
    !sw_wr_en |=> (($past(sw_rd_data[5:0]) & ~sw_rd_data[5:0]) == 6'h0));

  p_evt_sets_r4: assert property (@(posedge clk) disable iff (!rst_q_n)
    (|exc_evt) |=> (($past(exc_evt) & ~sw_rd_data[5:0]) == 6'h0));

  p_trap_unmasked_r5: assert property (@(posedge clk) disable iff (!rst_q_n)
    ((trap_req & sw_rd_data[12:7]) == 6'h0) && ((trap_req & ~exc_evt) == 6'h0));

  p_fault_hold_r7: assert property (@(posedge clk) disable iff (!rst_q_n)
    (sw_wr_en && ((sw_wr_data & ~cap_mask) != 32'h0))
      |=> (wr_fault && (sw_rd_data[31:6] == $past(sw_rd_data[31:6]))));

  p_no_fault_r7: assert property (@(posedge clk) disable iff (!rst_q_n)
    !(sw_wr_en && ((sw_wr_data & ~cap_mask) != 32'h0)) |=> !wr_fault);

  p_cap_daz_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    !cap_mask[6] |-> !daz_en);

  p_round_onehot_r9: assert property (@(posedge clk) disable iff (!rst_q_n)
    $countones({rnd_nearest, rnd_down, rnd_up, rnd_zero}) == 1);

  p_ftz_r10: assert property (@(posedge clk) disable iff (!rst_q_n)
    ftz_en == sw_rd_data[15]);
endmodule

bind fpctl_csr fcsr_chk u_chk (
  .clk        (clk),
  .rst_q_n    (rst_q_n),
  .sw_wr_en   (sw_wr_en),
  .sw_wr_data (sw_wr_data),
  .sw_rd_data (sw_rd_data),
  .cap_mask   (cap_mask),
  .wr_fault   (wr_fault),
  .exc_evt    (exc_evt),
  .trap_req   (trap_req),
  .rnd_nearest(rnd_nearest),
  .rnd_down   (rnd_down),
  .rnd_up     (rnd_up),
  .rnd_zero   (rnd_zero),
  .ftz_en     (ftz_en),
  .daz_en     (daz_en)
);

// File: tb/fpctl_csr_tb.sv
`timescale 1ns/1ps
module fpctl_csr_tb;
  localparam real CLK_P = 20.0;
  localparam logic [31:0] CAP_D = 32'h0000FFFF;
  localparam logic [31:0] CAP_N = 32'h0000FFBF;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        we;
  logic [31:0] wd;
  logic [5:0]  ev;

  logic [31:0] rd0, rd1, cap0, cap1;
  logic        flt0, flt1;
  logic [5:0]  trp0, trp1;
  logic        rn0, rdn0, ru0, rz0, ftz0, daz0;
  logic        rn1, rdn1, ru1, rz1, ftz1, daz1;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [15:0] m0, m1;
  bit          mf0, mf1;

  always #(CLK_P/2) clk = ~clk;

  fpctl_csr #(.HAS_DAZ(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .sw_wr_en(we), .sw_wr_data(wd),
    .sw_rd_data(rd0), .cap_mask(cap0), .wr_fault(flt0),
    .exc_evt(ev), .trap_req(trp0),
    .rnd_nearest(rn0), .rnd_down(rdn0), .rnd_up(ru0), .rnd_zero(rz0),
    .ftz_en(ftz0), .daz_en(daz0));

  fpctl_csr #(.HAS_DAZ(1'b0)) u_dut_nd (
    .clk(clk), .rst_n(rst_n), .sw_wr_en(we), .sw_wr_data(wd),
    .sw_rd_data(rd1), .cap_mask(cap1), .wr_fault(flt1),
    .exc_evt(ev), .trap_req(trp1),
    .rnd_nearest(rn1), .rnd_down(rdn1), .rnd_up(ru1), .rnd_zero(rz1),
    .ftz_en(ftz1), .daz_en(daz1));

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] model_nxt(input logic [15:0] cur, input logic w,
      input logic [31:0] d, input logic [5:0] e, input logic [31:0] cap, output bit f);
    logic [15:0] r;
    f = w && ((d & ~cap) != 32'h0);
    r = (w && !f) ? d[15:0] : cur;
    r[5:0] = r[5:0] | e;
    return r;
  endfunction

  function automatic logic [3:0] rc_exp(input logic [15:0] v);
    case (v[14:13])
      2'b00:   return 4'b1000;
      2'b01:   return 4'b0100;
      2'b10:   return 4'b0010;
      default: return 4'b0001;
    endcase
  endfunction

  task automatic check_outs(input string tag, input logic [31:0] rd, input logic f,
      input logic [3:0] rc, input logic ftz, input logic daz,
      input logic [15:0] m, input bit mf);
    chk("R3 R4 R6", {tag, " rd"}, rd, {16'h0, m});
    chk("R7", {tag, " fault"}, {31'h0, f}, {31'h0, mf});
    chk("R9", {tag, " round"}, {28'h0, rc}, {28'h0, rc_exp(m)});
    chk("R10", {tag, " ftz/daz"}, {30'h0, ftz, daz}, {30'h0, m[15], m[6]});
  endtask

  // Called just after a falling edge.
  task automatic step(input logic w, input logic [31:0] d, input logic [5:0] e);
    we = w; wd = d; ev = e;
    #1;
    chk("R5", "trap dut", {26'h0, trp0}, {26'h0, e & ~m0[12:7]});
    chk("R5", "trap nd",  {26'h0, trp1}, {26'h0, e & ~m1[12:7]});
    m0 = model_nxt(m0, w, d, e, CAP_D, mf0);
    m1 = model_nxt(m1, w, d, e, CAP_N, mf1);
    @(negedge clk);
    check_outs("dut", rd0, flt0, {rn0, rdn0, ru0, rz0}, ftz0, daz0, m0, mf0);
    check_outs("nd",  rd1, flt1, {rn1, rdn1, ru1, rz1}, ftz1, daz1, m1, mf1);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0C5A));
    rst_n = 1'b0; we = 1'b0; wd = 32'h0; ev = 6'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    m0 = 16'h1F80; m1 = 16'h1F80; mf0 = 0; mf1 = 0;

    // R1 reset value, R8 capability masks
    chk("R1", "reset dut", rd0, 32'h00001F80);
    chk("R1", "reset nd", rd1, 32'h00001F80);
    chk("R1", "reset fault", {30'h0, flt0, flt1}, 32'h0);
    chk("R8", "cap dut", cap0, CAP_D);
    chk("R8", "cap nd", cap1, CAP_N);

    // R4: masked events set flags, no trap
    step(1'b0, 32'h0, 6'b000001);
    step(1'b0, 32'h0, 6'b100100);
    chk("R4", "flags after masked events", {26'h0, rd0[5:0]}, 32'h25);
    // R3: idle cycle keeps flags
    step(1'b0, 32'h0, 6'h0);
    chk("R3", "sticky flags", {26'h0, rd0[5:0]}, 32'h25);
    // R6: write clears flags, unmasks all, round down; same-cycle event ORed
    step(1'b1, 32'h0000_2000, 6'b000010);
    chk("R6", "write plus event", rd0, 32'h0000_2002);
    // R5: unmasked event traps
    step(1'b0, 32'h0, 6'b111111);
    // R2: field positions; masks only on overflow (bit 10) and precision (bit 12)
    step(1'b1, 32'h0000_C000 | 32'h1400 | 32'h40 | 32'h08, 6'h0);
    chk("R2", "layout dut", rd0, 32'h0000_D448);
    chk("R8", "daz write nd faults", {31'h0, flt1}, 32'h1);
    chk("R10", "daz enable dut", {31'h0, daz0}, 32'h1);
    // R7: reserved high bit with events in the same cycle
    step(1'b1, 32'h0010_0000, 6'b010000);
    chk("R7", "reserved write fault", {31'h0, flt0}, 32'h1);
    chk("R7", "reserved write keep", rd0, 32'h0000_D458);
    step(1'b0, 32'h0, 6'h0);
    chk("R7", "fault one cycle", {31'h0, flt0}, 32'h0);
    // R9: each rounding code
    for (int k = 0; k < 4; k++) begin
      step(1'b1, {16'h0, k[1:0], 13'h1F80 >> 0}, 6'h0);
    end

    // Random phase
    for (int n = 0; n < 1500; n++) begin
      logic        w;
      logic [31:0] d;
      logic [5:0]  e;
      w = ($urandom % 4) == 0;
      d = {16'h0, 16'($urandom)};
      case ($urandom % 8)
        0: d = d | (32'h1 << (16 + ($urandom % 16)));
        1: d = d | 32'h40;
        default: ;
      endcase
      e = 6'($urandom) & 6'($urandom);
      step(w, d, e);
    end

    we = 1'b0; ev = 6'h0;
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule